// File: doc/BRIEF.md
# Analog Scan Sequencer Controller

This block is the digital control for a twelve-input, ten-bit successive-approximation converter. Software programs a control word, a channel-enable mask and, by way of a register bus, reads back one result register per input. A conversion run is launched by a software write, by a rising edge on an on-chip timer trigger, or by a rising edge on an external trigger pin. The control word selects which of the three is live. The converter core itself is abstract: the sequencer hands it a start pulse, a channel index and a self-test selection, then waits for the core's busy signal to rise and fall before it picks up the ten-bit code.

Three run modes exist. Single mode converts one programmed input. One-pass scan walks every enabled input once, lowest index first. Continuous scan repeats the walk until software drops the run bit. Stored codes may be reduced to eight bits by a two-place right shift. For a self test, the core can be told to convert one of three internal levels (ground, half reference, full reference) instead of its pin.

The state machine has five states. IDLE waits for an accepted trigger. LAUNCH drives the one-cycle start pulse. WAIT_ACK waits for the core's busy to rise. CONVERT waits for busy to fall. STORE writes the code and picks the next step: another LAUNCH for the next enabled input, a wrap back to LAUNCH on the lowest enabled input in continuous scan, or a return to IDLE. A continuous scan that is stopped in mid-pass goes from STORE to IDLE.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control word, the mask, the status word, every result register and `irq` read zero.
- R2: Register map (word addresses): 0 = control, 1 = mask, 2 = status, 16+n = result of input n. Control fields are: bit 0 run, bits 2:1 mode (0 single, 1 one-pass scan, 2 continuous scan, 3 acts as single), bits 4:3 source (0 software, 1 timer, 2 external, 3 none), bit 5 eight-bit shift, bit 6 self-test enable, bits 8:7 self-test level, bits 12:9 single-mode input. In single mode, one conversion of the programmed input lands in its result register. An input index of 12 or more starts nothing.
- R3: One-pass scan converts each input whose bit in the 12-bit mask is set, exactly once, in ascending index order. It leaves the result registers of masked-off inputs untouched. A scan with an all-zero mask converts nothing and raises the completion flag at once.
- R4: Continuous scan restarts from the lowest enabled input after each pass while run stays 1. Once run is written to 0, at most the conversion already under way completes, and no further conversion starts.
- R5: With the software source, a write of the control word with run = 1 and source = 0 starts the sequence. With the timer or external source, a rising edge of the selected input starts it while run = 1; the external pin passes through a two-stage synchronizer. Edges on the unselected input, and software writes, start nothing.
- R6: Any trigger that arrives while the sequencer is not idle is ignored and adds no conversion.
- R7: When the shift bit is set at store time, the stored value is the ten-bit code shifted right by two.
- R8: With self-test enabled, `core_diag_en` is 1 and `core_diag_sel` carries the level field (0 ground, 1 half reference, 2 full reference). The code returned for that level is stored in the result register of the input being sequenced.
- R9: Status bit 1 (`irq`) is set at the end of a single conversion or of each full scan pass. It holds until a status write with bit 1 = 1 clears it. A status write with bit 1 = 0 leaves it set.
- R10: `core_start` is a one-cycle pulse, and it is issued only with an input index below 12. `core_chan` is held stable while the core is busy. The code is captured after busy falls.
- R11: Status bit 0 reads 1 from an accepted trigger until the sequence returns to IDLE, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| tmr_trig | input | 1 | Timer trigger, rising edge |
| ext_trig | input | 1 | External trigger pin, asynchronous, rising edge |
| core_start | output | 1 | Start pulse to the converter core |
| core_chan | output | 4 | Input index to convert |
| core_diag_en | output | 1 | Convert an internal level instead of the pin |
| core_diag_sel | output | 2 | Internal level select |
| core_busy | input | 1 | Converter core busy |
| core_result | input | 10 | Conversion code, valid after busy falls |
| irq | output | 1 | Completion flag |

## Verification
The bound checker watches the core handshake on every cycle. It confirms that the start pulse lasts one cycle, that it carries an in-range index and comes with the busy status, and that the channel holds steady during a conversion. It also confirms the flag's rules: it is set after every completion and sticks until a clearing write. Scan order, the skipping of masked-off inputs, the shift, the self-test codes, trigger source selection, the dropping of triggers that arrive while busy, and the stop point of a continuous scan can only be shown by the bench's scenarios. There a stub core records each channel it was asked for and returns codes that the bench predicts on its own.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT_ACK,
        ST_CONVERT,
        ST_STORE
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_ONEPASS = 2'd1,
        MODE_CONT    = 2'd2,
        MODE_RSVD    = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'd0,
        SRC_TIMER = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_NONE  = 2'd3
    } trig_src_e;

    // bit 0 run, 2:1 mode, 4:3 source, 5 shift, 6 self-test, 8:7 level, 12:9 input
    typedef struct packed {
        logic [3:0] chan;
        logic [1:0] diag_sel;
        logic       diag_en;
        logic       shift8;
        trig_src_e  src;
        scan_mode_e mode;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MASK = 1;
    localparam int ADDR_STAT = 2;
    localparam int RES_BASE  = 16;
    localparam int STAT_BUSY = 0;
    localparam int STAT_IRQ  = 1;

endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src,
    input  logic      run,
    input  logic      sw_go,
    input  logic      tmr_trig,
    input  logic      ext_trig,
    output logic      start_req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev_q;
    logic                   tmr_prev_q;
    logic                   sw_go_q;
    logic                   ext_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_trig;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_trig};
            end
        end
    endgenerate

    assign ext_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev_q <= 1'b0;
            tmr_prev_q <= 1'b0;
            sw_go_q    <= 1'b0;
        end else begin
            ext_prev_q <= ext_s;
            tmr_prev_q <= tmr_trig;
            sw_go_q    <= sw_go;
        end
    end

    // software start is delayed one cycle so the new control word is in place
    always_comb begin
        unique case (src)
            SRC_SOFT:  start_req = sw_go_q;
            SRC_TIMER: start_req = run && tmr_trig && !tmr_prev_q;
            SRC_EXT:   start_req = run && ext_s && !ext_prev_q;
            default:   start_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH  = 12,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  scan_mode_e      mode_i,
    input  logic            run_i,
    input  logic [NCH-1:0]  mask_i,
    input  logic [3:0]      single_ch_i,
    input  logic            core_busy,
    output logic            core_start,
    output logic [CH_W-1:0] core_chan,
    output logic            store_en,
    output logic            pass_done,
    output logic            seq_busy
);
    seq_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q, cur_d;
    scan_mode_e      mode_q, mode_d;
    logic [NCH-1:0]  mask_q, mask_d;
    logic            done_c;

    logic            live_first_ok, first_ok, nxt_ok;
    logic [CH_W-1:0] live_first_idx, first_idx, nxt_idx;

    function automatic logic is_scan(scan_mode_e m);
        return (m == MODE_ONEPASS) || (m == MODE_CONT);
    endfunction

    // lowest set bit above 'above' (above = -1 searches from 0)
    always_comb begin
        live_first_ok  = 1'b0;
        live_first_idx = '0;
        first_ok       = 1'b0;
        first_idx      = '0;
        nxt_ok         = 1'b0;
        nxt_idx        = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                live_first_ok  = 1'b1;
                live_first_idx = CH_W'(i);
            end
            if (mask_q[i]) begin
                first_ok  = 1'b1;
                first_idx = CH_W'(i);
            end
            if (mask_q[i] && (i > int'(cur_q))) begin
                nxt_ok  = 1'b1;
                nxt_idx = CH_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        mode_d  = mode_q;
        mask_d  = mask_q;
        done_c  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    mode_d = mode_i;
                    mask_d = mask_i;
                    if (is_scan(mode_i)) begin
                        if (live_first_ok) begin
                            cur_d   = live_first_idx;
                            state_d = ST_LAUNCH;
                        end else begin
                            done_c = 1'b1;
                        end
                    end else if (int'(single_ch_i) < NCH) begin
                        cur_d   = CH_W'(single_ch_i);
                        state_d = ST_LAUNCH;
                    end
                end
            end
            ST_LAUNCH:   state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (core_busy) state_d = ST_CONVERT;
            ST_CONVERT:  if (!core_busy) state_d = ST_STORE;
            ST_STORE: begin
                if (!is_scan(mode_q)) begin
                    done_c  = 1'b1;
                    state_d = ST_IDLE;
                end else if (nxt_ok) begin
                    if (mode_q == MODE_CONT && !run_i) begin
                        state_d = ST_IDLE;
                    end else begin
                        cur_d   = nxt_idx;
                        state_d = ST_LAUNCH;
                    end
                end else begin
                    done_c = 1'b1;
                    if (mode_q == MODE_CONT && run_i && first_ok) begin
                        cur_d   = first_idx;
                        state_d = ST_LAUNCH;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            mode_q  <= MODE_SINGLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            mode_q  <= mode_d;
            mask_q  <= mask_d;
        end
    end

    always_comb begin
        core_start = (state_q == ST_LAUNCH);
        store_en   = (state_q == ST_STORE);
        seq_busy   = (state_q != ST_IDLE);
        pass_done  = done_c;
        core_chan  = cur_q;
    end

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 12,
    parameter int CH_W   = 4,
    parameter int RES_W  = 10,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              store_en,
    input  logic [CH_W-1:0]   store_ch,
    input  logic [RES_W-1:0]  core_result,
    input  logic              pass_done,
    input  logic              seq_busy,
    output ctrl_t             ctrl,
    output logic [NCH-1:0]    mask,
    output logic              irq,
    output logic              sw_go
);
    localparam int SHIFT = 2;

    logic [NCH*RES_W-1:0] res_flat;
    logic [RES_W-1:0]     store_val;
    ctrl_t                wr_ctrl;
    logic                 wr_ctrl_en, wr_mask_en, wr_stat_en;

    assign wr_ctrl    = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign wr_ctrl_en = bus_we && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign wr_mask_en = bus_we && (bus_addr == ADDR_W'(ADDR_MASK));
    assign wr_stat_en = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
    assign sw_go      = wr_ctrl_en && wr_ctrl.run && (wr_ctrl.src == SRC_SOFT);
    assign store_val  = ctrl.shift8 ? (core_result >> SHIFT) : core_result;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            mask <= '0;
            irq  <= 1'b0;
        end else begin
            if (wr_ctrl_en) ctrl <= wr_ctrl;
            if (wr_mask_en) mask <= bus_wdata[NCH-1:0];
            if (pass_done)
                irq <= 1'b1;
            else if (wr_stat_en && bus_wdata[STAT_IRQ])
                irq <= 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_res
            logic [RES_W-1:0] res_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    res_q <= '0;
                else if (store_en && (store_ch == CH_W'(g)))
                    res_q <= store_val;
            end
            assign res_flat[g*RES_W +: RES_W] = res_q;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[CTRL_W-1:0] = ctrl;
        end else if (bus_addr == ADDR_W'(ADDR_MASK)) begin
            bus_rdata[NCH-1:0] = mask;
        end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            bus_rdata[STAT_BUSY] = seq_busy;
            bus_rdata[STAT_IRQ]  = irq;
        end else if ((int'(bus_addr) >= RES_BASE) && (int'(bus_addr) < RES_BASE + NCH)) begin
            bus_rdata[RES_W-1:0] = res_flat[(int'(bus_addr) - RES_BASE)*RES_W +: RES_W];
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH         = 12,
    parameter int RES_W       = 10,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_trig,
    input  logic              ext_trig,
    output logic              core_start,
    output logic [3:0]        core_chan,
    output logic              core_diag_en,
    output logic [1:0]        core_diag_sel,
    input  logic              core_busy,
    input  logic [RES_W-1:0]  core_result,
    output logic              irq
);
    localparam int CH_W = 4;

    ctrl_t           ctrl;
    logic [NCH-1:0]  mask;
    logic            sw_go;
    logic            start_req;
    logic            store_en;
    logic            pass_done;
    logic            seq_busy;
    logic [CH_W-1:0] cur_chan;

    adc_seq_regs #(
        .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .store_en(store_en), .store_ch(cur_chan), .core_result(core_result),
        .pass_done(pass_done), .seq_busy(seq_busy),
        .ctrl(ctrl), .mask(mask), .irq(irq), .sw_go(sw_go)
    );

    adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .src(ctrl.src), .run(ctrl.run), .sw_go(sw_go),
        .tmr_trig(tmr_trig), .ext_trig(ext_trig),
        .start_req(start_req)
    );

    adc_seq_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .mode_i(ctrl.mode), .run_i(ctrl.run),
        .mask_i(mask), .single_ch_i(ctrl.chan), .core_busy(core_busy),
        .core_start(core_start), .core_chan(cur_chan), .store_en(store_en),
        .pass_done(pass_done), .seq_busy(seq_busy)
    );

    assign core_chan     = cur_chan;
    assign core_diag_en  = ctrl.diag_en;
    assign core_diag_sel = ctrl.diag_sel;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int NCH    = 12,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_start,
    input logic [3:0]        core_chan,
    input logic              core_busy,
    input logic              irq,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              seq_busy,
    input logic              pass_done
);
    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr == ADDR_W'(2)) && bus_wdata[1];

    a_r10_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    a_r10_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && $past(core_busy)) |-> $stable(core_chan));

    a_r2_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (int'(core_chan) < NCH));

    a_r11_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> seq_busy);

    a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> irq);

    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq);

endmodule

bind adc_seq_ctrl adc_seq_chk #(.NCH(NCH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_chan(core_chan),
    .core_busy(core_busy), .irq(irq), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .seq_busy(seq_busy), .pass_done(pass_done)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 12;
    localparam int CONV = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tmr_trig = 1'b0;
    logic        ext_trig = 1'b0;
    logic        core_start;
    logic [3:0]  core_chan;
    logic        core_diag_en;
    logic [1:0]  core_diag_sel;
    logic        core_busy;
    logic [9:0]  core_result;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    int base = 0;
    int conv_count = 0;
    int cnt = 0;
    bit finished = 0;
    logic [3:0] log_ch [256];
    logic [3:0] s_ch;
    logic       s_diag;
    logic [1:0] s_sel;
    int exp_res [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_trig(tmr_trig),
        .ext_trig(ext_trig), .core_start(core_start), .core_chan(core_chan),
        .core_diag_en(core_diag_en), .core_diag_sel(core_diag_sel),
        .core_busy(core_busy), .core_result(core_result), .irq(irq)
    );

    function automatic int model_code(int ch, bit diag, int sel);
        if (diag) return (sel == 1) ? 512 : (sel == 2) ? 1023 : 0;
        return (base + ch * 85) % 1024;
    endfunction

    function automatic int stored(int code, bit shift);
        return shift ? (code >> 2) : code;
    endfunction

    function automatic logic [15:0] mk_ctrl(bit run, int mode, int src, bit shift,
                                            bit diag, int dsel, int ch);
        return {3'b000, 4'(ch), 2'(dsel), diag, shift, 2'(src), 2'(mode), run};
    endfunction

    // behavioural converter core
    always @(posedge clk) begin
        if (!rst_n) begin
            core_busy   <= 1'b0;
            core_result <= '0;
            cnt         <= 0;
        end else if (core_start && !core_busy) begin
            core_busy  <= 1'b1;
            cnt        <= CONV - 1;
            s_ch       <= core_chan;
            s_diag     <= core_diag_en;
            s_sel      <= core_diag_sel;
            log_ch[conv_count % 256] <= core_chan;
            conv_count <= conv_count + 1;
        end else if (core_busy) begin
            if (cnt == 0) begin
                core_busy   <= 1'b0;
                core_result <= 10'(model_code(int'(s_ch), s_diag, int'(s_sel)));
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(int addr, logic [15:0] data);
        @(negedge clk);
        bus_addr  = 5'(addr);
        bus_wdata = data;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(int addr, output int data);
        @(negedge clk);
        bus_addr = 5'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic wait_irq(string tag);
        int t = 0;
        while (!irq && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check({tag, " completion flag"}, int'(irq), 1);
    endtask

    task automatic clear_irq();
        bus_write(2, 16'h0002);
    endtask

    task automatic check_all_results(string tag);
        for (int c = 0; c < NCH; c++) begin
            int v;
            bus_read(16 + c, v);
            check(tag, v, exp_res[c]);
        end
    endtask

    task automatic pulse_tmr();
        @(negedge clk);
        tmr_trig = 1'b1;
        @(negedge clk);
        tmr_trig = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk);
        ext_trig = 1'b1;
        repeat (4) @(negedge clk);
        ext_trig = 1'b0;
    endtask

    initial begin
        int v, c0, k, ch, cat;
        int unused;
        logic [11:0] m;
        bit sh;
        unused = $urandom(32'd20240611);
        for (int i = 0; i < NCH; i++) exp_res[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(0, v);  check("R1 ctrl", v, 0);
        bus_read(1, v);  check("R1 mask", v, 0);
        bus_read(2, v);  check("R1 status", v, 0);
        check("R1 irq", int'(irq), 0);
        check_all_results("R1 results");

        // R2 single mode, R9 flag behaviour
        ch = int'($urandom % 12);
        base = int'($urandom % 1024);
        bus_write(0, mk_ctrl(1, 0, 0, 0, 0, 0, ch));
        wait_irq("R2 single");
        exp_res[ch] = model_code(ch, 0, 0);
        check_all_results("R2 single result");
        bus_read(2, v);  check("R9 status after done", v, 2);
        bus_write(2, 16'h0000);
        bus_read(2, v);  check("R9 write0 keeps flag", v, 2);
        clear_irq();
        bus_read(2, v);  check("R9 w1c clears", v, 0);
        check("R9 irq port", int'(irq), 0);

        // R2 out-of-range input
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 0, 0, 0, 0, 0, 12));
        repeat (100) @(negedge clk);
        check("R2 index 12 no conversion", conv_count - c0, 0);
        bus_read(2, v);  check("R2 index 12 status", v, 0);

        // R3 / R7 / R10 random one-pass scans
        for (int it = 0; it < 6; it++) begin
            m = 12'($urandom);
            if (m == 0) m = 12'h001;
            sh = 1'($urandom);
            base = int'($urandom % 1024);
            bus_write(1, {4'b0, m});
            c0 = conv_count;
            bus_write(0, mk_ctrl(1, 1, 0, sh, 0, 0, 0));
            wait_irq("R3 scan");
            check("R3 conversion count", conv_count - c0, $countones(m));
            k = 0;
            for (int c = 0; c < NCH; c++) begin
                if (m[c]) begin
                    check("R3 ascending order", int'(log_ch[(c0 + k) % 256]), c);
                    exp_res[c] = stored(model_code(c, 0, 0), sh);
                    k++;
                end
            end
            check_all_results("R3 R7 scan results");
            clear_irq();
        end

        // R3 empty mask
        bus_write(1, 16'h0000);
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        check("R3 empty mask flag", int'(irq), 1);
        check("R3 empty mask no conversion", conv_count - c0, 0);
        clear_irq();

        // R5 timer source, R6 triggers while busy, R11 busy status
        bus_write(1, 16'h0081);
        base = int'($urandom % 1024);
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 1, 1, 0, 0, 0, 0));
        repeat (60) @(negedge clk);
        check("R5 sw write under timer source", conv_count - c0, 0);
        pulse_ext();
        repeat (60) @(negedge clk);
        check("R5 unselected ext edge", conv_count - c0, 0);
        pulse_tmr();
        repeat (20) @(negedge clk);
        pulse_tmr();
        bus_read(2, v);  check("R11 busy during scan", v & 1, 1);
        repeat (30) @(negedge clk);
        pulse_tmr();
        wait_irq("R5 timer scan");
        repeat (100) @(negedge clk);
        check("R6 timer pulses while busy ignored", conv_count - c0, 2);
        exp_res[0] = model_code(0, 0, 0);
        exp_res[7] = model_code(7, 0, 0);
        bus_read(2, v);  check("R11 idle status", v & 1, 0);
        clear_irq();

        // R5 external source
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 0, 2, 0, 0, 0, 5));
        pulse_tmr();
        repeat (60) @(negedge clk);
        check("R5 unselected timer edge", conv_count - c0, 0);
        pulse_ext();
        wait_irq("R5 ext single");
        check("R5 ext one conversion", conv_count - c0, 1);
        exp_res[5] = model_code(5, 0, 0);
        check_all_results("R5 ext result");
        clear_irq();

        // R6 software restart while busy
        bus_write(1, 16'h0FFF);
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
        repeat (40) @(negedge clk);
        bus_write(0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
        wait_irq("R6 sw scan");
        repeat (100) @(negedge clk);
        check("R6 sw write while busy ignored", conv_count - c0, 12);
        for (int c = 0; c < NCH; c++) exp_res[c] = model_code(c, 0, 0);
        clear_irq();

        // R4 continuous scan and stop
        bus_write(1, 16'h00A5);
        base = int'($urandom % 1024);
        c0 = conv_count;
        bus_write(0, mk_ctrl(1, 2, 0, 0, 0, 0, 0));
        k = 0;
        while (conv_count < c0 + 9 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        bus_write(0, mk_ctrl(0, 2, 0, 0, 0, 0, 0));
        cat = conv_count;
        k = 0;
        do begin
            bus_read(2, v);
            k++;
        end while ((v & 1) != 0 && k < 400);
        check("R4 stop after current", (conv_count - cat <= 1) ? 1 : 0, 1);
        c0 = conv_count;
        repeat (300) @(negedge clk);
        check("R4 no restart after stop", conv_count - c0, 0);
        check("R4 passes flagged", int'(irq), 1);
        check("R4 wrap order", int'(log_ch[(cat - 5) % 256]), 0);
        check("R4 wrap order next", int'(log_ch[(cat - 4) % 256]), 2);
        clear_irq();

        // R8 self-test levels, with R7 shift
        for (int s = 0; s < 3; s++) begin
            bus_write(0, mk_ctrl(1, 0, 0, 0, 1, s, 3));
            check("R8 diag enable out", int'(core_diag_en), 1);
            check("R8 diag select out", int'(core_diag_sel), s);
            wait_irq("R8 diag");
            bus_read(16 + 3, v);
            check("R8 diag level code", v, model_code(3, 1, s));
            clear_irq();
        end
        bus_write(0, mk_ctrl(1, 0, 0, 1, 1, 2, 9));
        wait_irq("R8 diag shifted");
        bus_read(16 + 9, v);
        check("R7 R8 shifted full level", v, 255);
        clear_irq();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule